// File: doc/BRIEF.md
# Hardware Button Volume Controller

This block turns three active-low push buttons (volume up, volume down and mute) into a 6-bit master attenuation level and a mute flag for an audio output path. Each button passes through a two-flop synchroniser and a debouncer that is clocked by a sample-enable tick. Only the released-to-pressed transition of a debounced button counts as a press. Accepted presses step the attenuation within saturating limits and update the mute flag according to a selectable mute convention.

There are two conventions. In the dedicated-button convention, the mute button toggles mute, and up or down clears it. In the chord convention, the mute pin is ignored. Pressing up and down together sets mute, and a single up or down press clears it. Single presses are held for a short window so that a late second button can still turn them into a chord.

A small write port holds the enable, convention and interrupt-enable bits, which are loaded from a configuration word after reset. It also clears a sticky press-status bit that can drive an interrupt line.

Top module: `hw_volume_ctrl`

## Requirements
- R1: While reset is applied and after it is released, the level is 0, mute is clear and the status bit is clear. Within three clocks of release, the control bits take the value of `cfg_word` (bit 0 enable, bit 1 convention, bit 2 interrupt enable).
- R2: A cycle with `reg_wr` high loads `reg_wdata` bit 0 into enable, bit 1 into convention and bit 2 into interrupt enable. Writing 1 to bit 3 clears the status bit.
- R3: A button counts as pressed or released only after its synchronised level has differed from the debounced state on 16 consecutive sample ticks. A shorter pulse has no effect, and only the press transition produces an event.
- R4: The level is an attenuation in which 0 is loudest. Up lowers it by 1 and stops at 0, and down raises it by 1 and stops at 63.
- R5: With convention 0, each mute press toggles the mute flag.
- R6: With convention 0, an up or down press steps the level and clears mute in the same update.
- R7: With convention 1, mute-button presses change neither the level, the mute flag nor the status bit.
- R8: With convention 1, when up and down are both pressed within 8 sample ticks of each other, mute is set and the level is unchanged.
- R9: With convention 1, an up or down press that is not joined by the other button within 8 sample ticks steps the level and clears mute.
- R10: While enable is 0, button presses change neither the level nor the mute flag.
- R11: While interrupt enable is 1, every accepted press sets the status bit. The bit stays set until it is cleared through R2, and `vol_irq` equals the status bit ANDed with interrupt enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sample_tick | input | 1 | Debounce and window sample enable |
| cfg_word | input | 3 | Control bits loaded after reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 4 | Write data: enable, convention, interrupt enable, status clear |
| up_n | input | 1 | Volume-up button, low when pressed |
| down_n | input | 1 | Volume-down button, low when pressed |
| mute_n | input | 1 | Mute button, low when pressed |
| ctl_enable | output | 1 | Enable bit |
| ctl_format | output | 1 | Mute convention bit |
| ctl_irq_en | output | 1 | Interrupt-enable bit |
| vol_status | output | 1 | Sticky press status |
| vol_irq | output | 1 | Interrupt request |
| volume | output | 6 | Attenuation level |
| muted | output | 1 | Mute flag |

## Verification
A pin change reaches the debouncer after two synchroniser clocks. The press pulse appears one clock after the 16th differing tick. With convention 0, the level, the mute flag and the status bit move on the following clock. With convention 1, a chord acts on the clock after the second press pulse, and a lone press acts on the clock of the 8th tick after its pulse. Register writes take effect on the next clock. The bench holds a behavioural reference that advances on every rising edge and compares all outputs 1 ns after it. Directed checks are made only once the buttons have been released and at least 20 ticks have passed, which is after every due cycle.

// File: rtl/hvc_pkg.sv
package hvc_pkg;
  localparam int NUM_BTN  = 3;
  localparam int BTN_UP   = 0;
  localparam int BTN_DN   = 1;
  localparam int BTN_MUTE = 2;

  typedef enum logic [1:0] {
    MUTE_KEEP = 2'd0,
    MUTE_SET  = 2'd1,
    MUTE_CLR  = 2'd2,
    MUTE_TOG  = 2'd3
  } mute_op_e;
endpackage

// File: rtl/hvc_debounce.sv
module hvc_debounce #(
  parameter int SAMPLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic btn_n,
  output logic press_o
);
  localparam int CW = (SAMPLES > 1) ? $clog2(SAMPLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(SAMPLES - 1);

  logic          s1_q, s2_q;
  logic          stab_q, stab_d;
  logic          press_q, press_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    stab_d  = stab_q;
    cnt_d   = cnt_q;
    press_d = 1'b0;
    if (tick) begin
      if (s2_q != stab_q) begin
        if (cnt_q == LAST) begin
          stab_d  = s2_q;
          cnt_d   = '0;
          press_d = s2_q;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end else begin
        cnt_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q    <= 1'b0;
      s2_q    <= 1'b0;
      stab_q  <= 1'b0;
      cnt_q   <= '0;
      press_q <= 1'b0;
    end else begin
      s1_q    <= ~btn_n;
      s2_q    <= s1_q;
      stab_q  <= stab_d;
      cnt_q   <= cnt_d;
      press_q <= press_d;
    end
  end

  assign press_o = press_q;

  // R3
  press_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    press_q |=> !press_q);
  // R3
  press_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    press_q |-> (stab_q && !$past(stab_q)));
endmodule

// File: rtl/hvc_event.sv
module hvc_event
  import hvc_pkg::*;
#(
  parameter int WINDOW = 8
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick,
  input  logic     en,
  input  logic     fmt,
  input  logic     acc_up,
  input  logic     acc_dn,
  input  logic     acc_mute,
  output logic     step_up,
  output logic     step_dn,
  output mute_op_e mute_op
);
  localparam int WCW = (WINDOW > 1) ? $clog2(WINDOW) : 1;
  localparam logic [WCW-1:0] WLAST = WCW'(WINDOW - 1);

  logic           pend_q, pend_d;
  logic           dir_q, dir_d;
  logic [WCW-1:0] pcnt_q, pcnt_d;

  always_comb begin
    step_up = 1'b0;
    step_dn = 1'b0;
    mute_op = MUTE_KEEP;
    pend_d  = pend_q;
    dir_d   = dir_q;
    pcnt_d  = pcnt_q;
    if (!en || !fmt) begin
      pend_d  = 1'b0;
      pcnt_d  = '0;
      step_up = acc_up & ~acc_dn;
      step_dn = acc_dn & ~acc_up;
      if (acc_up || acc_dn)  mute_op = MUTE_CLR;
      else if (acc_mute)     mute_op = MUTE_TOG;
    end else if (pend_q) begin
      if (dir_q ? acc_dn : acc_up) begin
        mute_op = MUTE_SET;
        pend_d  = 1'b0;
      end else if (tick) begin
        if (pcnt_q == WLAST) begin
          pend_d  = 1'b0;
          pcnt_d  = '0;
          step_up = dir_q;
          step_dn = ~dir_q;
          mute_op = MUTE_CLR;
        end else begin
          pcnt_d = pcnt_q + 1'b1;
        end
      end
    end else if (acc_up && acc_dn) begin
      mute_op = MUTE_SET;
    end else if (acc_up || acc_dn) begin
      pend_d = 1'b1;
      dir_d  = acc_up;
      pcnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      dir_q  <= 1'b0;
      pcnt_q <= '0;
    end else begin
      pend_q <= pend_d;
      dir_q  <= dir_d;
      pcnt_q <= pcnt_d;
    end
  end

  // R10
  pend_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !pend_q);
  // R4
  one_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(step_up && step_dn));
  // R8
  chord_no_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mute_op == MUTE_SET) |-> !(step_up || step_dn));
endmodule

// File: rtl/hvc_level.sv
module hvc_level
  import hvc_pkg::*;
#(
  parameter int VOL_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_up,
  input  logic             step_dn,
  input  mute_op_e         mute_op,
  output logic [VOL_W-1:0] vol_o,
  output logic             muted_o
);
  localparam logic [VOL_W-1:0] VMAX = {VOL_W{1'b1}};

  logic [VOL_W-1:0] vol_q, vol_d;
  logic             mute_q, mute_d;

  always_comb begin
    vol_d = vol_q;
    if (step_up && vol_q != '0)   vol_d = vol_q - 1'b1;
    if (step_dn && vol_q != VMAX) vol_d = vol_q + 1'b1;
    unique case (mute_op)
      MUTE_SET: mute_d = 1'b1;
      MUTE_CLR: mute_d = 1'b0;
      MUTE_TOG: mute_d = ~mute_q;
      default:  mute_d = mute_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vol_q  <= '0;
      mute_q <= 1'b0;
    end else begin
      vol_q  <= vol_d;
      mute_q <= mute_d;
    end
  end

  assign vol_o   = vol_q;
  assign muted_o = mute_q;

  // R4
  floor_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_up && vol_q == '0) |=> vol_q == '0);
  // R4
  ceil_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_dn && vol_q == VMAX) |=> vol_q == VMAX);
  // R4
  unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vol_q) |-> ((VOL_W'(vol_q - $past(vol_q)) == VOL_W'(1)) ||
                         (VOL_W'($past(vol_q) - vol_q) == VOL_W'(1))));
endmodule

// File: rtl/hw_volume_ctrl.sv
module hw_volume_ctrl
  import hvc_pkg::*;
#(
  parameter int VOL_W       = 6,
  parameter int DB_SAMPLES  = 16,
  parameter int CHORD_TICKS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_tick,
  input  logic [2:0]       cfg_word,
  input  logic             reg_wr,
  input  logic [3:0]       reg_wdata,
  input  logic             up_n,
  input  logic             down_n,
  input  logic             mute_n,
  output logic             ctl_enable,
  output logic             ctl_format,
  output logic             ctl_irq_en,
  output logic             vol_status,
  output logic             vol_irq,
  output logic [VOL_W-1:0] volume,
  output logic             muted
);
  logic rs1_q, rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rst_i <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rst_i <= rs1_q;
    end
  end

  logic [NUM_BTN-1:0] btn_n_vec, press;
  assign btn_n_vec = {mute_n, down_n, up_n};

  for (genvar b = 0; b < NUM_BTN; b++) begin : g_btn
    hvc_debounce #(.SAMPLES(DB_SAMPLES)) u_db (
      .clk     (clk),
      .rst_n   (rst_i),
      .tick    (sample_tick),
      .btn_n   (btn_n_vec[b]),
      .press_o (press[b])
    );
  end

  logic load_q;
  logic en_q, fmt_q, ie_q, stat_q;
  logic en_d, fmt_d, ie_d, stat_d;
  logic acc_up, acc_dn, acc_mute, any_acc;

  assign acc_up   = press[BTN_UP] & en_q;
  assign acc_dn   = press[BTN_DN] & en_q;
  assign acc_mute = press[BTN_MUTE] & en_q & ~fmt_q;
  assign any_acc  = acc_up | acc_dn | acc_mute;

  always_comb begin
    en_d   = en_q;
    fmt_d  = fmt_q;
    ie_d   = ie_q;
    stat_d = stat_q;
    if (reg_wr) begin
      en_d  = reg_wdata[0];
      fmt_d = reg_wdata[1];
      ie_d  = reg_wdata[2];
    end else if (load_q) begin
      en_d  = cfg_word[0];
      fmt_d = cfg_word[1];
      ie_d  = cfg_word[2];
    end
    if (reg_wr && reg_wdata[3]) stat_d = 1'b0;
    if (ie_q && any_acc)        stat_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      load_q <= 1'b1;
      en_q   <= 1'b0;
      fmt_q  <= 1'b0;
      ie_q   <= 1'b0;
      stat_q <= 1'b0;
    end else begin
      load_q <= 1'b0;
      en_q   <= en_d;
      fmt_q  <= fmt_d;
      ie_q   <= ie_d;
      stat_q <= stat_d;
    end
  end

  logic     step_up, step_dn;
  mute_op_e mute_op;

  hvc_event #(.WINDOW(CHORD_TICKS)) u_event (
    .clk      (clk),
    .rst_n    (rst_i),
    .tick     (sample_tick),
    .en       (en_q),
    .fmt      (fmt_q),
    .acc_up   (acc_up),
    .acc_dn   (acc_dn),
    .acc_mute (acc_mute),
    .step_up  (step_up),
    .step_dn  (step_dn),
    .mute_op  (mute_op)
  );

  hvc_level #(.VOL_W(VOL_W)) u_level (
    .clk     (clk),
    .rst_n   (rst_i),
    .step_up (step_up),
    .step_dn (step_dn),
    .mute_op (mute_op),
    .vol_o   (volume),
    .muted_o (muted)
  );

  assign ctl_enable = en_q;
  assign ctl_format = fmt_q;
  assign ctl_irq_en = ie_q;
  assign vol_status = stat_q;
  assign vol_irq    = stat_q & ie_q;

  // R10
  disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_i)
    !en_q |=> ($stable(volume) && $stable(muted)));
  // R11
  status_clear_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (reg_wr && reg_wdata[3] && !(ie_q && any_acc)) |=> !vol_status);
  // R11
  status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (vol_status && !(reg_wr && reg_wdata[3])) |=> vol_status);
  // R2
  write_load_chk: assert property (@(posedge clk) disable iff (!rst_i)
    reg_wr |=> (ctl_enable == $past(reg_wdata[0]) && ctl_irq_en == $past(reg_wdata[2])));
  // R7
  mute_pin_ignored_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (en_q && fmt_q && press[BTN_MUTE] && !press[BTN_UP] && !press[BTN_DN] && !ie_q && !vol_status)
      |=> !vol_status);
endmodule

// File: tb/hw_volume_ctrl_tb.sv
`timescale 1ns/100ps
module hw_volume_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n, sample_tick, reg_wr;
  logic [2:0] cfg_word;
  logic [3:0] reg_wdata;
  logic       up_n, down_n, mute_n;
  logic       ctl_enable, ctl_format, ctl_irq_en, vol_status, vol_irq, muted;
  logic [5:0] volume;

  always #2.5 clk = ~clk;

  hw_volume_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .cfg_word(cfg_word),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .up_n(up_n), .down_n(down_n),
    .mute_n(mute_n), .ctl_enable(ctl_enable), .ctl_format(ctl_format),
    .ctl_irq_en(ctl_irq_en), .vol_status(vol_status), .vol_irq(vol_irq),
    .volume(volume), .muted(muted)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  bit model_on = 0;

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // tick every second clock
  bit tick_ph = 0;
  always @(negedge clk) begin
    tick_ph = ~tick_ph;
    sample_tick = tick_ph;
  end

  // behavioural reference
  int m_s1[3], m_s2[3], m_st[3], m_cnt[3], m_pr[3];
  int m_en, m_fmt, m_ie, m_stat, m_vol, m_mute, m_pend, m_pup, m_pcnt;

  always @(posedge clk) begin
    if (model_on) begin
      int a_up, a_dn, a_mu, s_up, s_dn, mop; // mop 0 keep 1 set 2 clr 3 tog
      int raw[3];
      a_up = m_pr[0] & m_en;
      a_dn = m_pr[1] & m_en;
      a_mu = m_pr[2] & m_en & (m_fmt == 0);
      s_up = 0; s_dn = 0; mop = 0;
      if (m_en == 0 || m_fmt == 0) begin
        m_pend = 0; m_pcnt = 0;
        s_up = a_up & !a_dn; s_dn = a_dn & !a_up;
        if (a_up || a_dn) mop = 2; else if (a_mu) mop = 3;
      end else if (m_pend) begin
        if (m_pup ? a_dn : a_up) begin mop = 1; m_pend = 0; end
        else if (sample_tick) begin
          if (m_pcnt == 7) begin
            m_pend = 0; m_pcnt = 0; mop = 2;
            if (m_pup) s_up = 1; else s_dn = 1;
          end else m_pcnt++;
        end
      end else if (a_up && a_dn) mop = 1;
      else if (a_up || a_dn) begin m_pend = 1; m_pup = a_up; m_pcnt = 0; end
      if (s_up && m_vol > 0) m_vol--;
      if (s_dn && m_vol < 63) m_vol++;
      if (mop == 1) m_mute = 1;
      else if (mop == 2) m_mute = 0;
      else if (mop == 3) m_mute = !m_mute;
      if (reg_wr && reg_wdata[3]) m_stat = 0;
      if (m_ie && (a_up || a_dn || a_mu)) m_stat = 1;
      if (reg_wr) begin m_en = reg_wdata[0]; m_fmt = reg_wdata[1]; m_ie = reg_wdata[2]; end
      raw[0] = !up_n; raw[1] = !down_n; raw[2] = !mute_n;
      for (int i = 0; i < 3; i++) begin
        m_pr[i] = 0;
        if (sample_tick) begin
          if (m_s2[i] != m_st[i]) begin
            if (m_cnt[i] == 15) begin m_st[i] = m_s2[i]; m_cnt[i] = 0; m_pr[i] = m_s2[i]; end
            else m_cnt[i]++;
          end else m_cnt[i] = 0;
        end
        m_s2[i] = m_s1[i];
        m_s1[i] = raw[i];
      end
      #1;
      check("R4 volume", volume, m_vol);
      check("R5 muted", muted, m_mute);
      check("R11 status", vol_status, m_stat);
      check("R11 irq", vol_irq, m_stat & m_ie);
      check("R2 ctl", {ctl_irq_en, ctl_format, ctl_enable}, {m_ie[0], m_fmt[0], m_en[0]});
    end
  end

  task automatic wait_ticks(int n);
    repeat (n * 2) @(negedge clk);
  endtask

  task automatic push(bit u, bit d, bit m);
    @(negedge clk);
    up_n = !u; down_n = !d; mute_n = !m;
    wait_ticks(20);
    up_n = 1; down_n = 1; mute_n = 1;
    wait_ticks(20);
  endtask

  task automatic wr(logic [3:0] v);
    @(negedge clk);
    reg_wr = 1; reg_wdata = v;
    @(negedge clk);
    reg_wr = 0; reg_wdata = 0;
  endtask

  initial begin
    rst_n = 0; reg_wr = 0; reg_wdata = 0; cfg_word = 3'b001;
    up_n = 1; down_n = 1; mute_n = 1; sample_tick = 0;
    repeat (4) @(negedge clk);
    check("R1 reset volume", volume, 0);
    check("R1 reset muted", muted, 0);
    check("R1 reset status", vol_status, 0);
    check("R1 reset irq", vol_irq, 0);
    rst_n = 1;
    repeat (6) @(negedge clk);
    check("R1 cfg enable", ctl_enable, 1);
    check("R1 cfg format", ctl_format, 0);
    check("R1 cfg irq_en", ctl_irq_en, 0);
    m_en = 1; m_fmt = 0; m_ie = 0; m_stat = 0; m_vol = 0; m_mute = 0;
    m_pend = 0; m_pup = 0; m_pcnt = 0;
    for (int i = 0; i < 3; i++) begin
      m_s1[i] = 0; m_s2[i] = 0; m_st[i] = 0; m_cnt[i] = 0; m_pr[i] = 0;
    end
    model_on = 1;

    push(1, 0, 0);
    check("R4 floor at 0", volume, 0);
    repeat (3) push(0, 1, 0);
    check("R4 down steps", volume, 3);
    push(0, 0, 1);
    check("R5 toggle on", muted, 1);
    push(0, 0, 1);
    check("R5 toggle off", muted, 0);
    push(0, 0, 1);
    push(0, 1, 0);
    check("R6 down volume", volume, 4);
    check("R6 down unmutes", muted, 0);

    @(negedge clk); up_n = 0; wait_ticks(10); up_n = 1; wait_ticks(20);
    check("R3 short glitch", volume, 4);

    wr(4'b0000);
    check("R2 enable cleared", ctl_enable, 0);
    push(0, 1, 0);
    check("R10 disabled volume", volume, 4);
    push(0, 0, 1);
    check("R10 disabled mute", muted, 0);

    wr(4'b0101);
    push(1, 0, 0);
    check("R6 up volume", volume, 3);
    check("R11 status set", vol_status, 1);
    check("R11 irq set", vol_irq, 1);
    wait_ticks(10);
    check("R11 status sticky", vol_status, 1);
    wr(4'b1101);
    check("R11 status cleared", vol_status, 0);
    check("R2 irq_en readback", ctl_irq_en, 1);

    wr(4'b0011);
    check("R2 format readback", ctl_format, 1);
    push(0, 0, 1);
    check("R7 mute pin ignored", muted, 0);
    check("R7 level kept", volume, 3);
    push(1, 1, 0);
    check("R8 chord mutes", muted, 1);
    check("R8 chord level kept", volume, 3);
    push(0, 1, 0);
    check("R9 single down level", volume, 4);
    check("R9 single down unmutes", muted, 0);
    @(negedge clk); up_n = 0; wait_ticks(4); down_n = 0;
    wait_ticks(20); up_n = 1; down_n = 1; wait_ticks(20);
    check("R8 staggered chord mutes", muted, 1);
    check("R8 staggered level kept", volume, 4);
    push(1, 0, 0);
    check("R9 single up level", volume, 3);
    check("R9 single up unmutes", muted, 0);

    wr(4'b0001);
    repeat (65) push(0, 1, 0);
    check("R4 ceiling at 63", volume, 63);
    push(1, 0, 0);
    check("R4 up from ceiling", volume, 62);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule